// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block receives 32-bit words from an external transmitter. The transmitter supplies its own bit clock, a frame-sync line and a data line, and none of them is related to the system clock. The block brings each line into the system clock domain through a chain of flops and finds bit-clock edges there, so the serial lines are in effect oversampled. A frame starts when frame sync is seen active on a sampling edge. The data bit on the first sampling edge that finds frame sync inactive is the most significant bit. The next 31 sampling edges supply the remaining bits.

When a word is complete, it is copied into a holding register, `valid_o` pulses for one cycle and the ready flag is set. The consumer acknowledges the word with `rd_i`, which clears the ready flag. If a second word lands while the ready flag is still set and unacknowledged, the overrun flag is raised. Separate inputs set the active level of each of the three serial lines. A synchronous receive reset returns the receiver to idle without touching the system reset.

Top module: `framed_rx`

## Requirements
- R1: Each serial line passes through two system-clock flops. `valid_o` goes high at the third rising system clock edge after the final sampling edge of a word appears at the pin.
- R2: Every level on the serial lines is received correctly if it is held for at least two system clock periods.
- R3: A word is 32 bits, received most significant bit first. The first received bit appears at `word_o[31]`.
- R4: After reset the receiver is idle and all outputs are zero. Bit-clock edges and data seen while frame sync is inactive and no frame is open produce no word.
- R5: `valid_o` is high for exactly one cycle per completed word. `word_o` holds that word until the next word completes or a receive reset occurs.
- R6: `ready_o` is set when a word completes and is cleared by `rd_i`. If `rd_i` arrives in the same cycle as a completion, `ready_o` stays set.
- R7: If a word completes while `ready_o` is set and `rd_i` is low, `ovr_o` is set. `rd_i` clears `ovr_o`.
- R8: Frame sync may stay active for several bit clocks. The first data bit is the one sampled on the first sampling edge that finds frame sync inactive. After that, frame sync is ignored until the word ends.
- R9: With `clk_pol_i`=0, data is sampled on the rising edge of `sclk_i`; with 1, on the falling edge. `dat_pol_i`=1 inverts the received data. `fs_pol_i`=0 makes frame sync active high; 1 makes it active low.
- R10: `rx_rst_i` is a synchronous reset. It returns the receiver to idle, discards any partial word and clears `word_o`, `ready_o` and `ovr_o`.
- R11: There is no upper limit on the bit period. Words sent with very long bit-clock half periods are received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_rst_i | input | 1 | Synchronous receive reset |
| clk_pol_i | input | 1 | Bit clock sampling edge select |
| dat_pol_i | input | 1 | Data inversion select |
| fs_pol_i | input | 1 | Frame-sync active-low select |
| sclk_i | input | 1 | External bit clock |
| sfs_i | input | 1 | External frame sync |
| sdat_i | input | 1 | External serial data |
| rd_i | input | 1 | Word acknowledge, clears ready and overrun |
| word_o | output | WORD_W (32) | Last completed word |
| valid_o | output | 1 | One-cycle pulse on word completion |
| ready_o | output | 1 | Unacknowledged word present |
| ovr_o | output | 1 | Word completed over an unacknowledged one |

## Verification
Most internal faults appear on `word_o` only when a word completes, which is 32 bit periods after the frame start. A bit counter that is off by one shifts or truncates the word. A framing state that stays stuck never raises `valid_o`. A stale or corrupted shift register shows up as wrong bit values at that same moment. Faults in the flags are visible sooner: a mishandled acknowledge or a coincident completion shows on `ready_o` or `ovr_o` in the cycle after `rd_i`. Synchronizer depth and edge detection are exposed as a shift of `valid_o` by whole system clock cycles.

// File: rtl/framed_rx_pkg.sv
package framed_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/rx_edge.sv
module rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/rx_shift.sv
module rx_shift
  import framed_rx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic              fs_i,
  input  logic              dat_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              ready_o,
  output logic              ovr_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q, word_q;
  logic              valid_q, ready_q, ovr_q;
  logic              last_bit, done;

  assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));
  assign done     = smp_i && (st_q == ST_SHIFT) && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (smp_i) begin
        case (st_q)
          ST_IDLE:  if (fs_i) st_q <= ST_ARMED;
          ST_ARMED: if (!fs_i) begin  // first edge with frame sync released carries MSB
            sh_q  <= {{(WORD_W-1){1'b0}}, dat_i};
            cnt_q <= CNT_W'(1);
            st_q  <= ST_SHIFT;
          end
          ST_SHIFT: begin
            sh_q  <= {sh_q[WORD_W-2:0], dat_i};
            cnt_q <= cnt_q + CNT_W'(1);
            if (last_bit) begin
              st_q    <= ST_IDLE;
              word_q  <= {sh_q[WORD_W-2:0], dat_i};
              valid_q <= 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (clr_i) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (done)      ready_q <= 1'b1;
      else if (rd_i) ready_q <= 1'b0;
      if (done && ready_q && !rd_i) ovr_q <= 1'b1;
      else if (rd_i)                ovr_q <= 1'b0;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign ready_o = ready_q;
  assign ovr_o   = ovr_q;

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  ready_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);
  // R6
  rd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done) |=> !ready_o);
  // R7
  ovr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> valid_o);
  // R4
  idle_no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> (st_q != ST_SHIFT));
  // R10
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ready_o && !ovr_o && st_q == ST_IDLE));
endmodule

// File: rtl/framed_rx.sv
module framed_rx #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_rst_i,
  input  logic              clk_pol_i,
  input  logic              dat_pol_i,
  input  logic              fs_pol_i,
  input  logic              sclk_i,
  input  logic              sfs_i,
  input  logic              sdat_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              ready_o,
  output logic              ovr_o
);
  logic [2:0] pin_lvl, pin_s;
  logic       smp;

  // polarity ahead of the sync chain: a flop reset value of 0 is the inactive level
  assign pin_lvl = {sfs_i ^ fs_pol_i, sdat_i ^ dat_pol_i, sclk_i ^ clk_pol_i};

  rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_lvl),
    .q_o   (pin_s)
  );

  rx_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_s[0]),
    .rise_o(smp)
  );

  rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rx_rst_i),
    .smp_i  (smp),
    .fs_i   (pin_s[2]),
    .dat_i  (pin_s[1]),
    .rd_i   (rd_i),
    .word_o (word_o),
    .valid_o(valid_o),
    .ready_o(ready_o),
    .ovr_o  (ovr_o)
  );
endmodule

// File: tb/tb_framed_rx.sv
`timescale 1ns/1ps
module tb_framed_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_rst = 1'b0, clk_pol = 1'b0, dat_pol = 1'b0, fs_pol = 1'b0;
  logic sclk = 1'b0, sfs = 1'b0, sdat = 1'b0, rd = 1'b0;
  logic [31:0] word;
  logic valid, ready, ovr;

  int total = 0, bad = 0, vcount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  framed_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_rst_i(rx_rst),
    .clk_pol_i(clk_pol), .dat_pol_i(dat_pol), .fs_pol_i(fs_pol),
    .sclk_i(sclk), .sfs_i(sfs), .sdat_i(sdat), .rd_i(rd),
    .word_o(word), .valid_o(valid), .ready_o(ready), .ovr_o(ovr)
  );

  // behavioural reference: pin history delayed by the synchronizer latency
  logic [2:0]  hist[$];
  int          m_state = 0, m_cnt = 0;
  logic [31:0] m_sh = '0, m_word = '0;
  logic        m_valid = 1'b0, m_ready = 1'b0, m_ovr = 1'b0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      hist = '{3'b000, 3'b000, 3'b000, 3'b000};
      m_state = 0; m_cnt = 0; m_sh = '0; m_word = '0;
      m_valid = 0; m_ready = 0; m_ovr = 0;
    end else begin
      logic edge_seen, fs_a, d_a, fin;
      hist.push_back({sfs ^ fs_pol, sdat ^ dat_pol, sclk ^ clk_pol});
      while (hist.size() > 4) void'(hist.pop_front());
      edge_seen = hist[1][0] && !hist[0][0];
      fs_a = hist[1][2];
      d_a  = hist[1][1];
      fin  = 1'b0;
      if (rx_rst) begin
        m_state = 0; m_cnt = 0; m_word = '0;
        m_valid = 0; m_ready = 0; m_ovr = 0;
      end else begin
        m_valid = 0;
        if (edge_seen) begin
          if (m_state == 0) begin
            if (fs_a) m_state = 1;
          end else if (m_state == 1) begin
            if (!fs_a) begin m_sh = {31'b0, d_a}; m_cnt = 1; m_state = 2; end
          end else begin
            m_sh = {m_sh[30:0], d_a};
            m_cnt++;
            if (m_cnt == 32) begin fin = 1; m_state = 0; end
          end
        end
        if (fin) begin
          m_word = m_sh; m_valid = 1;
          if (m_ready && !rd) m_ovr = 1;
          else if (rd) m_ovr = 0;
          m_ready = 1;
        end else if (rd) begin
          m_ready = 0; m_ovr = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (valid) vcount++;
      chk(valid === m_valid, "R1 valid_o timing", {31'b0, valid}, {31'b0, m_valid});
      chk(word === m_word, "R3 word_o", word, m_word);
      chk(ready === m_ready, "R6 ready_o", {31'b0, ready}, {31'b0, m_ready});
      chk(ovr === m_ovr, "R7 ovr_o", {31'b0, ovr}, {31'b0, m_ovr});
    end
  end

  task automatic phase(input bit c, input bit f, input bit d, input int half);
    sclk = c ^ clk_pol;
    sfs  = f ^ fs_pol;
    sdat = d ^ dat_pol;
    repeat (half) @(negedge clk);
  endtask

  // fsb clocks with frame sync active, then nbits data bits
  task automatic send(input logic [31:0] w, input int fsb, input int half, input int nbits);
    for (int i = 0; i < fsb; i++) begin
      phase(1'b0, 1'b1, 1'($urandom), half);
      phase(1'b1, 1'b1, sdat ^ dat_pol, half);
    end
    for (int i = 0; i < nbits; i++) begin
      phase(1'b0, 1'b0, w[31-i], half);
      phase(1'b1, 1'b0, w[31-i], half);
    end
    phase(1'b0, 1'b0, 1'b0, half);
    repeat (4) @(negedge clk);
  endtask

  task automatic ack();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk(word == 0 && !valid && !ready && !ovr, "R4 reset outputs", {word[28:0], valid, ready, ovr}, 0);

    // R4 clock and data ignored without frame start
    for (int i = 0; i < 40; i++) begin
      phase(1'b0, 1'b0, 1'($urandom), 2);
      phase(1'b1, 1'b0, 1'($urandom), 2);
    end
    repeat (4) @(negedge clk);
    chk(vcount == 0 && !ready, "R4 no word while idle", vcount, 0);

    // R2 R3 minimum half period of two cycles
    v0 = vcount;
    send(32'hA5C3_0F1E, 1, 2, 32);
    chk(word == 32'hA5C3_0F1E, "R3 MSB-first word", word, 32'hA5C3_0F1E);
    chk(vcount == v0 + 1, "R5 one valid pulse", vcount, v0 + 1);
    chk(ready, "R6 ready set", {31'b0, ready}, 1);
    ack();
    chk(!ready, "R6 ready cleared by rd", {31'b0, ready}, 0);

    // R8 long frame sync
    send(32'h8000_0001, 4, 3, 32);
    chk(word == 32'h8000_0001, "R8 long frame sync", word, 32'h8000_0001);

    // R7 overrun
    send(32'h1234_5678, 1, 2, 32);
    chk(ovr && word == 32'h1234_5678, "R7 overrun set", {31'b0, ovr}, 1);
    ack();
    chk(!ovr && !ready, "R7 overrun cleared", {30'b0, ovr, ready}, 0);

    // R6 acknowledge held through a completion
    send(32'h0BAD_F00D, 1, 2, 32);
    rd = 1'b1;
    send(32'hCAFE_0001, 1, 2, 32);
    rd = 1'b0;
    @(negedge clk);
    chk(!ovr, "R6 coincident rd no overrun", {31'b0, ovr}, 0);
    chk(word == 32'hCAFE_0001, "R6 word during rd", word, 32'hCAFE_0001);

    // R10 receive reset mid-word
    send(32'hFFFF_FFFF, 1, 2, 10);
    send(32'h0, 1, 2, 0);
    rx_rst = 1'b1; repeat (2) @(negedge clk); rx_rst = 1'b0; @(negedge clk);
    chk(word == 0 && !ready && !ovr, "R10 receive reset clears", word, 0);
    send(32'h6E6E_0033, 1, 2, 32);
    chk(word == 32'h6E6E_0033, "R10 partial word discarded", word, 32'h6E6E_0033);
    ack();

    // R9 all polarities inverted
    rx_rst = 1'b1;
    clk_pol = 1'b1; dat_pol = 1'b1; fs_pol = 1'b1;
    sclk = 1'b1; sfs = 1'b1; sdat = 1'b1;
    repeat (4) @(negedge clk);
    rx_rst = 1'b0; @(negedge clk);
    send(32'hDEAD_BEEF, 2, 2, 32);
    chk(word == 32'hDEAD_BEEF, "R9 inverted polarities", word, 32'hDEAD_BEEF);
    ack();

    // R11 very long bit period
    send(32'h5A5A_C3C3, 1, 150, 32);
    chk(word == 32'h5A5A_C3C3, "R11 long bit period", word, 32'h5A5A_C3C3);
    ack();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule